// File: doc/BRIEF.md
# Serial Register Map Target with Burst Access and Power-Mode Gating

This block is the serial side of a sensing front end. It is a 4-wire SPI target (clock idle low, data captured on the rising edge and changed on the falling edge, most significant bit first) that gives an external host access to a 64-byte register map. The first byte of every chip-select frame is a command that holds a direction flag and a start address. Each following byte reads or writes one register, and the address steps up by one after every byte. The address stops at the top of the map and does not wrap.

On the core side the block takes the live measurement results: a 16-bit resistance value, a 16-bit inductance value and a 24-bit high-resolution inductance value. It also presents the whole configuration image and the current power mode. Multi-byte results are frozen when their lowest byte is read, so the upper bytes read later always belong to the same conversion. Configuration writes are accepted only in sleep mode. Thresholds, the interrupt selector and the mode register can be written in any mode. Shutdown needs a separate enable bit and returns every register to its reset value.

The serial inputs are brought into the core clock through synchronizers and edge detectors. The core clock must be at least several times faster than the serial clock.

Top module: `spiRegMap`

## Requirements
- R1: After reset the power mode is sleep (code 01). Register 0x01 reads 0x07, 0x02 reads 0x90, 0x03 reads 0xA0, 0x04 reads 0x03 and 0x0B reads 0x01. Every other writable register reads 0x00.
- R2: The command byte carries the direction in bit 7 (1 = read, 0 = write) and the start address in bits 6:0. Bytes are shifted most significant bit first, in clock-idle-low mode. Data is captured on rising edges and output changes on falling edges.
- R3: A write byte takes effect on the eighth rising clock edge of that byte. A frame that ends before its data byte is complete (for example 15 clocks, or only a command byte) changes no register.
- R4: While chip select stays low, each further byte addresses the next register and keeps the direction of the command byte. This holds for both bursts and single transfers.
- R5: The address stops at 0x3F. Burst bytes beyond 0x3F are not written, read as 0x00, and never wrap to 0x00.
- R6: Writes to read-only or unmapped addresses are ignored, and unmapped addresses read 0x00. Address 0x3E always reads 0x02 and 0x3F always reads 0xD4.
- R7: Configuration registers 0x01–0x05, 0x0C and 0x30–0x34 are written only while the mode is sleep (01). Otherwise the write is dropped.
- R8: Registers 0x06–0x0A and 0x16–0x19 can be written in any mode. Bits 1:0 of register 0x0B set the mode (00 active, 01 sleep, 10 shutdown) and read back with the upper bits as 0. A write of code 11 is ignored. A write of code 10 is ignored unless bit 1 of register 0x05 is already 1.
- R9: Entering shutdown returns every register, including the result snapshots, to its reset value and reports mode 10. The next chip-select assertion returns the mode to sleep.
- R10: Reading 0x21 returns the live resistance LSB and freezes resistance bits 15:8 (read at 0x22) and the inductance word (read at 0x23 LSB, 0x24 MSB).
- R11: Reading 0x38 returns the live bits 7:0 of the high-resolution value and freezes bits 23:8, which are read at 0x39 and 0x3A.
- R12: The serial output is driven low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| rpResult | input | 16 | Live resistance result |
| lResult | input | 16 | Live inductance result |
| hrResult | input | 24 | Live high-resolution inductance result |
| cfgImage | output | 512 | Register image, byte n at bits 8n+7:8n (writable registers and mode only) |
| modeOut | output | 2 | Current power mode code |

## Verification
Two full sweeps check the address-class decode. In each sweep the bench writes every address with a value derived from that address (address XOR 0xA5 in sleep, address XOR 0x3C in active), then reads the whole map back in one 64-byte burst. The two sweeps separate the sleep-only, any-mode, read-only and unmapped classes at every boundary. The long burst also exercises auto-increment across all 64 addresses. Short frames and writes that start at 0x3F confirm that a partial byte changes nothing and that the address does not wrap. The result inputs are changed between the LSB read and the upper-byte reads, which separates a frozen snapshot from a live path. Mode writes with code 11, with code 10 before and after the enable bit is set, and a wake-up frame cover the power-mode rules.

// File: rtl/spiRegMapPkg.sv
package spiRegMapPkg;
  localparam int MAP_DEPTH = 64;
  localparam int IDX_W = $clog2(MAP_DEPTH);
  localparam int CMD_ADDR_W = 7;
  localparam int RES_W = 16;
  localparam int HR_W = 24;
  localparam int LAST_ADDR = MAP_DEPTH - 1;

  localparam int ADDR_AUX = 5;
  localparam int ADDR_MODE = 11;
  localparam int ADDR_RP_LO = 33;
  localparam int ADDR_RP_HI = 34;
  localparam int ADDR_L_LO = 35;
  localparam int ADDR_L_HI = 36;
  localparam int ADDR_HR_LO = 56;
  localparam int ADDR_HR_MID = 57;
  localparam int ADDR_HR_HI = 58;
  localparam int ADDR_REV = 62;
  localparam int ADDR_ID = 63;
  localparam int SHUT_EN_BIT = 1;
  localparam logic [7:0] REV_CODE = 8'h02;
  localparam logic [7:0] ID_CODE = 8'hD4;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'b00,
    MODE_SLEEP  = 2'b01,
    MODE_SHUT   = 2'b10,
    MODE_RSVD   = 2'b11
  } pwrMode_e;

  typedef struct packed {
    logic                  frameStart;
    logic                  wrEn;
    logic                  loadTx;
    logic                  pastEnd;
    logic [CMD_ADDR_W-1:0] addr;
    logic [7:0]            wrData;
  } ctrlStrobe_t;

  function automatic logic isSleepOnly(input int a);
    return (a >= 1 && a <= 5) || a == 12 || (a >= 48 && a <= 52);
  endfunction

  function automatic logic isAnyMode(input int a);
    return (a >= 6 && a <= 10) || (a >= 22 && a <= 25);
  endfunction

  function automatic logic [7:0] cfgDefault(input int a);
    case (a)
      1:       return 8'h07;
      2:       return 8'h90;
      3:       return 8'hA0;
      4:       return 8'h03;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiRegMapPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        csN,
  input  logic        mosi,
  input  logic [7:0]  rdByte,
  output logic        miso,
  output ctrlStrobe_t stb
);
  localparam logic [CMD_ADDR_W-1:0] TOP_ADDR = CMD_ADDR_W'(LAST_ADDR);

  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic sclkPrev, csPrev;
  logic sclkNow, csNow, mosiNow;
  logic rise, fall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosi};
      sclkPrev <= sclkNow;
      csPrev   <= csNow;
    end
  end

  assign sclkNow = sclkSync[SYNC_STAGES-1];
  assign csNow   = csSync[SYNC_STAGES-1];
  assign mosiNow = mosiSync[SYNC_STAGES-1];
  assign rise    = sclkNow & ~sclkPrev & ~csNow;
  assign fall    = ~sclkNow & sclkPrev & ~csNow;

  logic [2:0] bitCnt;
  logic isCmd, isRead, pastEnd, loadPend;
  logic [CMD_ADDR_W-1:0] addr;
  logic [6:0] rxShift;
  logic [7:0] txShift;
  logic [7:0] rxByte;

  assign rxByte = {rxShift, mosiNow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      isCmd    <= 1'b1;
      isRead   <= 1'b0;
      pastEnd  <= 1'b0;
      loadPend <= 1'b0;
      addr     <= '0;
      rxShift  <= '0;
      txShift  <= '0;
    end else if (csNow) begin
      bitCnt   <= '0;
      isCmd    <= 1'b1;
      pastEnd  <= 1'b0;
      loadPend <= 1'b0;
      txShift  <= '0;
    end else if (rise) begin
      rxShift <= rxByte[6:0];
      bitCnt  <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) begin
        if (isCmd) begin
          isCmd    <= 1'b0;
          isRead   <= rxByte[7];
          addr     <= rxByte[6:0];
          loadPend <= rxByte[7];
        end else begin
          if (addr >= TOP_ADDR) pastEnd <= 1'b1;
          else addr <= addr + 1'b1;
          loadPend <= isRead;
        end
      end
    end else if (fall) begin
      if (loadPend) begin
        txShift  <= rdByte;
        loadPend <= 1'b0;
      end else begin
        txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  always_comb begin
    stb.frameStart = csPrev & ~csNow;
    stb.wrEn       = rise && bitCnt == 3'd7 && !isCmd && !isRead && !pastEnd;
    stb.loadTx     = fall && loadPend;
    stb.pastEnd    = pastEnd;
    stb.addr       = addr;
    stb.wrData     = rxByte;
  end

  assign miso = txShift[7] & ~csNow;

  // R3: a committed byte closes the bit count of that byte
  p_commit_8th_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> bitCnt == 3'd0);
  // R4: a data byte below the top steps the address by one
  p_burst_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rise && bitCnt == 3'd7 && !isCmd && addr < TOP_ADDR) |=> addr == $past(addr) + 1'b1);
  // R5: at the top the address never wraps inside a frame
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!csNow && addr == TOP_ADDR && !isCmd) |=> (csNow || addr == TOP_ADDR));
  // R12: quiet output while deselected
  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    csPrev |-> txShift == 8'h00);
endmodule

// File: rtl/regBank.sv
module regBank
  import spiRegMapPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            stb,
  input  logic [RES_W-1:0]       rpResult,
  input  logic [RES_W-1:0]       lResult,
  input  logic [HR_W-1:0]        hrResult,
  output logic [7:0]             rdByte,
  output logic [MAP_DEPTH*8-1:0] cfgImage,
  output logic [1:0]             modeOut
);
  logic [7:0] cfgByte [MAP_DEPTH];
  pwrMode_e modeQ;
  pwrMode_e wrMode;
  logic shutEn, modeWr, enterShut;

  assign wrMode    = pwrMode_e'(stb.wrData[1:0]);
  assign shutEn    = cfgByte[ADDR_AUX][SHUT_EN_BIT];
  assign modeWr    = stb.wrEn && stb.addr == CMD_ADDR_W'(ADDR_MODE) && modeQ != MODE_SHUT;
  assign enterShut = modeWr && wrMode == MODE_SHUT && shutEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_SLEEP;
    else if (enterShut) modeQ <= MODE_SHUT;
    else if (modeWr && (wrMode == MODE_ACTIVE || wrMode == MODE_SLEEP)) modeQ <= wrMode;
    else if (stb.frameStart && modeQ == MODE_SHUT) modeQ <= MODE_SLEEP;
  end

  assign modeOut = modeQ;

  for (genvar a = 0; a < MAP_DEPTH; a++) begin : g_byte
    if (isSleepOnly(a) || isAnyMode(a)) begin : g_store
      logic [7:0] q;
      logic hit;
      assign hit = stb.wrEn && stb.addr == CMD_ADDR_W'(a) &&
                   (isAnyMode(a) || modeQ == MODE_SLEEP);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= cfgDefault(a);
        else if (enterShut) q <= cfgDefault(a);
        else if (hit) q <= stb.wrData;
      end
      assign cfgByte[a] = q;
    end else if (a == ADDR_MODE) begin : g_mode
      assign cfgByte[a] = {6'b0, modeQ};
    end else begin : g_none
      assign cfgByte[a] = 8'h00;
    end
    assign cfgImage[a*8 +: 8] = cfgByte[a];
  end

  logic [7:0]       rpSnapHi;
  logic [RES_W-1:0] lSnap;
  logic [HR_W-9:0]  hrSnapHi;
  logic takeRp, takeHr;

  assign takeRp = stb.loadTx && !stb.pastEnd && stb.addr == CMD_ADDR_W'(ADDR_RP_LO);
  assign takeHr = stb.loadTx && !stb.pastEnd && stb.addr == CMD_ADDR_W'(ADDR_HR_LO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rpSnapHi <= '0;
      lSnap    <= '0;
      hrSnapHi <= '0;
    end else if (enterShut) begin
      rpSnapHi <= '0;
      lSnap    <= '0;
      hrSnapHi <= '0;
    end else begin
      if (takeRp) begin
        rpSnapHi <= rpResult[RES_W-1:8];
        lSnap    <= lResult;
      end
      if (takeHr) hrSnapHi <= hrResult[HR_W-1:8];
    end
  end

  always_comb begin
    rdByte = 8'h00;
    if (!stb.pastEnd) begin
      if (stb.addr < CMD_ADDR_W'(MAP_DEPTH)) rdByte = cfgByte[stb.addr[IDX_W-1:0]];
      case (stb.addr)
        CMD_ADDR_W'(ADDR_RP_LO):  rdByte = rpResult[7:0];
        CMD_ADDR_W'(ADDR_RP_HI):  rdByte = rpSnapHi;
        CMD_ADDR_W'(ADDR_L_LO):   rdByte = lSnap[7:0];
        CMD_ADDR_W'(ADDR_L_HI):   rdByte = lSnap[15:8];
        CMD_ADDR_W'(ADDR_HR_LO):  rdByte = hrResult[7:0];
        CMD_ADDR_W'(ADDR_HR_MID): rdByte = hrSnapHi[7:0];
        CMD_ADDR_W'(ADDR_HR_HI):  rdByte = hrSnapHi[15:8];
        CMD_ADDR_W'(ADDR_REV):    rdByte = REV_CODE;
        CMD_ADDR_W'(ADDR_ID):     rdByte = ID_CODE;
        default: ;
      endcase
    end
  end

  // R8: the reserved mode code never becomes the state
  p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    modeQ != MODE_RSVD);
  // R8: shutdown is reached only when the enable bit was set
  p_shut_enable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SHUT && $past(modeQ) != MODE_SHUT) |-> $past(shutEn));
  // R9: a new frame in shutdown returns to sleep
  p_wake_sleep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_SHUT && stb.frameStart) |=> modeQ == MODE_SLEEP);
  // R7: configuration byte 0x02 holds outside sleep
  p_sleep_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && stb.addr == 7'h02 && modeQ != MODE_SLEEP) |=> $stable(cfgByte[2]));
  // R10: the frozen inductance word only moves on an LSB read or shutdown
  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!takeRp && !enterShut) |=> $stable(lSnap));
endmodule

// File: rtl/spiRegMap.sv
module spiRegMap
  import spiRegMapPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclk,
  input  logic                   csN,
  input  logic                   mosi,
  output logic                   miso,
  input  logic [RES_W-1:0]       rpResult,
  input  logic [RES_W-1:0]       lResult,
  input  logic [HR_W-1:0]        hrResult,
  output logic [MAP_DEPTH*8-1:0] cfgImage,
  output logic [1:0]             modeOut
);
  ctrlStrobe_t stb;
  logic [7:0] rdByte;

  spiCtrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .rdByte(rdByte), .miso(miso), .stb(stb)
  );

  regBank i_bank (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rpResult(rpResult), .lResult(lResult), .hrResult(hrResult),
    .rdByte(rdByte), .cfgImage(cfgImage), .modeOut(modeOut)
  );
endmodule

// File: tb/test_spiRegMap.sv
module test_spiRegMap;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso;
  logic [15:0] rpIn = 16'h0000, lIn = 16'h0000;
  logic [23:0] hrIn = 24'h000000;
  logic [511:0] cfgImg;
  logic [1:0] modeO;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] txBuf [80];
  logic [7:0] rxBuf [80];
  logic [7:0] rv;

  always #2 clk = ~clk;

  spiRegMap i_spiRegMap (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .rpResult(rpIn), .lResult(lIn), .hrResult(hrIn), .cfgImage(cfgImg), .modeOut(modeO)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiFrame(input int nBits);
    @(negedge clk) csN = 1'b0;
    waitN(HALF);
    for (int b = 0; b < nBits; b++) begin
      @(negedge clk) mosi = txBuf[b/8][7 - (b%8)];
      waitN(HALF);
      sclk = 1'b1;
      rxBuf[b/8][7 - (b%8)] = miso;
      waitN(HALF);
      sclk = 1'b0;
    end
    waitN(HALF);
    csN = 1'b1;
    mosi = 1'b0;
    waitN(2*HALF);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d);
    txBuf[0] = {1'b0, a};
    txBuf[1] = d;
    spiFrame(16);
  endtask

  task automatic rdBurst(input logic [6:0] a, input int n);
    txBuf[0] = {1'b1, a};
    for (int i = 1; i <= n; i++) txBuf[i] = 8'h00;
    spiFrame(8*(n+1));
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] d);
    rdBurst(a, 1);
    d = rxBuf[1];
  endtask

  function automatic bit sleepOnlyB(input int a);
    return (a >= 1 && a <= 5) || a == 12 || (a >= 48 && a <= 52);
  endfunction
  function automatic bit anyB(input int a);
    return (a >= 6 && a <= 10) || (a >= 22 && a <= 25);
  endfunction
  function automatic logic [7:0] defB(input int a);
    case (a)
      1: return 8'h07;
      2: return 8'h90;
      3: return 8'hA0;
      4: return 8'h03;
      11: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] expSweep(input int a, input bit act, input logic [7:0] v);
    if (sleepOnlyB(a)) return act ? defB(a) : v;
    if (anyB(a)) return v;
    case (a)
      11: return act ? 8'h00 : 8'h01;
      33: return rpIn[7:0];
      34: return rpIn[15:8];
      35: return lIn[7:0];
      36: return lIn[15:8];
      56: return hrIn[7:0];
      57: return hrIn[15:8];
      58: return hrIn[23:16];
      62: return 8'h02;
      63: return 8'hD4;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitN(10);
    rstN = 1'b1;
    waitN(5);
    // R1 / R12 reset state
    chk("R1 mode after reset", modeO, 2'b01);
    chk("R12 miso idle", miso, 1'b0);
    chk("R1 image 0x01", cfgImg[8*1 +: 8], 8'h07);
    chk("R1 image 0x02", cfgImg[8*2 +: 8], 8'h90);
    chk("R1 image 0x06", cfgImg[8*6 +: 8], 8'h00);
    rdBurst(7'h01, 4);
    chk("R1 read 0x01", rxBuf[1], 8'h07);
    chk("R1 read 0x02", rxBuf[2], 8'h90);
    chk("R1 read 0x03", rxBuf[3], 8'hA0);
    chk("R1 read 0x04", rxBuf[4], 8'h03);
    rd1(7'h0B, rv);
    chk("R1 read mode", rv, 8'h01);
    // R5/R6 top of map and saturation on read
    rdBurst(7'h3E, 4);
    chk("R6 rev", rxBuf[1], 8'h02);
    chk("R6 id", rxBuf[2], 8'hD4);
    chk("R5 past end 1", rxBuf[3], 8'h00);
    chk("R5 past end 2 no wrap", rxBuf[4], 8'h00);
    // R2 single write and readback
    wr1(7'h06, 8'h5A);
    chk("R2 image 0x06", cfgImg[8*6 +: 8], 8'h5A);
    rd1(7'h06, rv);
    chk("R2 readback 0x06", rv, 8'h5A);
    // R3 short frames
    txBuf[0] = 8'h06; txBuf[1] = 8'hC3;
    spiFrame(15);
    rd1(7'h06, rv);
    chk("R3 15-clock frame", rv, 8'h5A);
    spiFrame(8);
    rd1(7'h06, rv);
    chk("R3 command-only frame", rv, 8'h5A);
    // R6 read-only and unmapped
    wr1(7'h3E, 8'h77);
    rd1(7'h3E, rv);
    chk("R6 write to rev ignored", rv, 8'h02);
    wr1(7'h10, 8'h99);
    rd1(7'h10, rv);
    chk("R6 unmapped reads zero", rv, 8'h00);
    // R4 burst write and read
    txBuf[0] = 8'h16; txBuf[1] = 8'h11; txBuf[2] = 8'h22; txBuf[3] = 8'h33; txBuf[4] = 8'h44;
    spiFrame(40);
    chk("R4 image 0x19", cfgImg[8*25 +: 8], 8'h44);
    rdBurst(7'h16, 4);
    for (int i = 0; i < 4; i++) chk("R4 burst readback", rxBuf[i+1], 8'h11 * (i+1));
    // R5 write burst from top does not wrap
    txBuf[0] = 8'h3F; txBuf[1] = 8'h11; txBuf[2] = 8'h22; txBuf[3] = 8'h33;
    spiFrame(32);
    rd1(7'h01, rv);
    chk("R5 no wrap write into 0x01", rv, 8'h07);
    // R10 resistance / inductance snapshot
    rpIn = 16'h1234; lIn = 16'hABCD;
    waitN(4);
    rd1(7'h21, rv);
    chk("R10 live rp lsb", rv, 8'h34);
    rpIn = 16'hFFFF; lIn = 16'h0000;
    rdBurst(7'h22, 3);
    chk("R10 frozen rp msb", rxBuf[1], 8'h12);
    chk("R10 frozen l lsb", rxBuf[2], 8'hCD);
    chk("R10 frozen l msb", rxBuf[3], 8'hAB);
    // R11 high-resolution snapshot
    hrIn = 24'h0A0B0C;
    waitN(4);
    rd1(7'h38, rv);
    chk("R11 live hr lsb", rv, 8'h0C);
    hrIn = 24'hFFFFFF;
    rdBurst(7'h39, 2);
    chk("R11 frozen hr mid", rxBuf[1], 8'h0B);
    chk("R11 frozen hr msb", rxBuf[2], 8'h0A);
    // R8 mode codes
    wr1(7'h0B, 8'h03);
    chk("R8 reserved code ignored", modeO, 2'b01);
    wr1(7'h0B, 8'h02);
    chk("R8 shutdown without enable ignored", modeO, 2'b01);
    wr1(7'h0B, 8'h00);
    chk("R8 active entered", modeO, 2'b00);
    // R7 sleep-only gating, any-mode writes
    wr1(7'h02, 8'h55);
    rd1(7'h02, rv);
    chk("R7 config write dropped in active", rv, 8'h90);
    wr1(7'h08, 8'hC3);
    rd1(7'h08, rv);
    chk("R8 threshold written in active", rv, 8'hC3);
    wr1(7'h0B, 8'h01);
    chk("R8 back to sleep", modeO, 2'b01);
    wr1(7'h02, 8'h55);
    rd1(7'h02, rv);
    chk("R7 config write in sleep", rv, 8'h55);
    // R9 shutdown
    wr1(7'h05, 8'h02);
    wr1(7'h0B, 8'h02);
    chk("R9 shutdown mode", modeO, 2'b10);
    chk("R9 0x02 defaulted", cfgImg[8*2 +: 8], 8'h90);
    chk("R9 0x05 defaulted", cfgImg[8*5 +: 8], 8'h00);
    chk("R9 0x06 defaulted", cfgImg[8*6 +: 8], 8'h00);
    rd1(7'h0B, rv);
    chk("R9 wake reads sleep", rv, 8'h01);
    chk("R9 wake mode", modeO, 2'b01);
    rdBurst(7'h22, 1);
    chk("R9 snapshot cleared", rxBuf[1], 8'h00);
    // R7/R8 sweep in sleep
    rpIn = 16'h5A3C; lIn = 16'h9187; hrIn = 24'hE1D2C3;
    for (int a = 0; a < 64; a++) if (a != 11) wr1(7'(a), 8'(a) ^ 8'hA5);
    rdBurst(7'h00, 64);
    for (int a = 0; a < 64; a++)
      chk($sformatf("R7 sleep sweep addr %0d", a), rxBuf[a+1], expSweep(a, 1'b0, 8'(a) ^ 8'hA5));
    // restore defaults through shutdown, then sweep in active
    wr1(7'h05, 8'h02);
    wr1(7'h0B, 8'h02);
    wr1(7'h0B, 8'h00);
    chk("R8 active for sweep", modeO, 2'b00);
    for (int a = 0; a < 64; a++) if (a != 11) wr1(7'(a), 8'(a) ^ 8'h3C);
    rdBurst(7'h00, 64);
    for (int a = 0; a < 64; a++)
      chk($sformatf("R8 active sweep addr %0d", a), rxBuf[a+1], expSweep(a, 1'b1, 8'(a) ^ 8'h3C));
    chk("R12 miso idle at end", miso, 1'b0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule